// File: doc/BRIEF.md
# NOR Flash Command and Program Engine

This block is a synthesizable behavioural model of a small NOR-style flash array that sits behind a simple host bus. The host issues single-cycle writes of an address and a data word. A command decoder watches these writes for multi-write sequences. It recognises single-word program, buffered (multi-word) program, sector erase, whole-array erase, an identification mode and a query mode. Stored data only changes when one of these sequences completes, so a stray write cannot alter it.

A write that completes a program or erase sequence starts an operation on an internal register-file array. The `busy` output then stays high for a number of cycles that depends on the operation. During that time, further writes are dropped and reads return a status word instead of array data. Apart from busy time, reads are combinational. Depending on the decoder mode, they return an array word, an identification word or a query-table entry.

Top module: `nor_cmd_engine`

## Requirements
- R1: After synchronous reset, `busy` and `err` are 0 and every array word reads 0xFFFF, even if an operation was running when reset came.
- R2: The word program sequence is 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then data@target. When it completes, the target word holds its old value ANDed with the data, so bits can only be cleared.
- R3: Sector erase is 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 written at any address in the sector. A sector is 16 words selected by address bits [7:4]. All its words become 0xFFFF and no other sector changes. `busy` is high for 32 cycles (2 per word).
- R4: Writing 0x10@0x555 as the sixth write of the erase sequence sets every array word to 0xFFFF. `busy` is high for 512 cycles.
- R5: A word program keeps `busy` high for 4 cycles. During that time `rdata` is a status word: bit 7 is the inverse of bit 7 of the data being programmed, and all other bits are 0. During an erase, the status word is 0x0000.
- R6: Writes that arrive while `busy` is high are ignored. They neither change the array nor advance the command decoder.
- R7: A write that breaks the two-write unlock prefix sends the decoder back to array-read mode. A single write outside a full sequence changes nothing.
- R8: Writing 0x98@0x055 enters query mode. This works from array-read mode or from identification mode. In query mode, a read at low address byte 0x10, 0x11, 0x12 or 0x13 returns 0x0051, 0x0052, 0x0059 or 0x0002, and any other address returns 0. A 0x98 written at any other address has no effect.
- R9: The unlock prefix followed by 0x90@0x555 enters identification mode. There, reads with address bit 0 equal to 0 return 0x00C3, and reads with bit 0 equal to 1 return 0x2A7E. Writing 0xF0 at any address leaves identification or query mode and returns to array reads.
- R10: Buffered program works as follows: unlock, 0x25 at an address in a 32-word page (bits [7:5]), count-minus-one, that many data@address writes, then 0x29. The array is unchanged until 0x29 arrives. All loaded words are then ANDed into the array in one operation, and `busy` is high for 4 plus the word count cycles.
- R11: The buffered program aborts with no array change and `err` set to 1 in two cases: a count-minus-one above 31, or a data write outside the page. Writing 0xF0 while the decoder is in array-read, identification or query mode clears `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle in which it is high |
| addr | input | 12 | Word address for writes and reads |
| wdata | input | 16 | Write data or command byte (low 8 bits) |
| rdata | output | 16 | Array word, identification word, query entry or status |
| busy | output | 1 | High while a program or erase runs |
| err | output | 1 | Sticky buffered-program abort flag |

## Verification
The bench probes several corner cases:
- It reprograms a word to confirm AND-only behaviour. A design that overwrote the word would return the new data rather than 0x0204.
- It measures the busy length of the sector, whole-array and buffered operations. A timer off by one cycle, or one that ignored sector size, shows up as a wrong count.
- It sends a three-write unlock during an erase and then a lone data write. A decoder that listened while busy would program that word.
- It reads a buffered target before the confirm byte, and aborts a buffered load both by an oversize count and by an out-of-page address. A design that wrote early or ignored the page check would show changed words or a clear `err`.

// File: rtl/nfl_pkg.sv
package nfl_pkg;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 16;
    localparam int ARR_W      = 8;
    localparam int SECT_AW    = 4;
    localparam int PAGE_AW    = 5;
    localparam int ARR_WORDS  = 1 << ARR_W;
    localparam int SECT_WORDS = 1 << SECT_AW;
    localparam int BUF_WORDS  = 1 << PAGE_AW;

    localparam logic [ADDR_W-1:0] UNLOCK_A0 = 12'h555;
    localparam logic [ADDR_W-1:0] UNLOCK_A1 = 12'h2AA;
    localparam logic [ADDR_W-1:0] QRY_ADDR  = 12'h055;

    typedef enum logic [1:0] {OP_PROG, OP_ERS_SECT, OP_ERS_CHIP, OP_BUF} op_kind_e;
    typedef enum logic [1:0] {MODE_ARRAY, MODE_ID, MODE_QRY} mode_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [ARR_W-1:0]    addr;
        logic [DATA_W-1:0]   data;
        logic [PAGE_AW:0]    cnt;
    } op_req_t;

    function automatic logic [DATA_W-1:0] id_word(input logic sel);
        return sel ? 16'h2A7E : 16'h00C3;
    endfunction

    function automatic logic [DATA_W-1:0] query_word(input logic [7:0] a);
        case (a)
            8'h10:   return 16'h0051;
            8'h11:   return 16'h0052;
            8'h12:   return 16'h0059;
            8'h13:   return 16'h0002;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/nfl_cmd_decode.sv
module nfl_cmd_decode
    import nfl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    output logic                start,
    output op_req_t             req,
    output logic                buf_clr,
    output logic                buf_we,
    output mode_e               mode,
    output logic                err
);
    typedef enum logic [3:0] {
        S_READ, S_U1, S_U2, S_PROG, S_ER1, S_ER2, S_ER3,
        S_BUFC, S_BUFD, S_BUFK, S_ID, S_QRY
    } dec_state_e;

    localparam int PG_W = ARR_W - PAGE_AW;

    dec_state_e          state, nxt;
    logic [PG_W-1:0]     page_q, page_n;
    logic [PAGE_AW:0]    left_q, left_n, cnt_q, cnt_n;
    logic [DATA_W-1:0]   tgt_q, tgt_n;
    logic                err_set, err_clr;
    logic [7:0]          cmd;
    logic                page_hit;

    assign cmd      = wdata[7:0];
    assign page_hit = (addr[ARR_W-1:PAGE_AW] == page_q);

    always_comb begin
        nxt     = state;
        page_n  = page_q;
        left_n  = left_q;
        cnt_n   = cnt_q;
        tgt_n   = tgt_q;
        start   = 1'b0;
        req     = '0;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        err_set = 1'b0;
        err_clr = 1'b0;
        if (wr_en && !busy) begin
            case (state)
                S_READ: begin
                    if (cmd == 8'hF0) err_clr = 1'b1;
                    else if (addr == UNLOCK_A0 && cmd == 8'hAA) nxt = S_U1;
                    else if (addr == QRY_ADDR && cmd == 8'h98) nxt = S_QRY;
                end
                S_U1: nxt = (addr == UNLOCK_A1 && cmd == 8'h55) ? S_U2 : S_READ;
                S_U2: begin
                    nxt = S_READ;
                    if (cmd == 8'h25) begin
                        nxt     = S_BUFC;
                        page_n  = addr[ARR_W-1:PAGE_AW];
                        buf_clr = 1'b1;
                    end else if (addr == UNLOCK_A0) begin
                        if (cmd == 8'hA0) nxt = S_PROG;
                        else if (cmd == 8'h80) nxt = S_ER1;
                        else if (cmd == 8'h90) nxt = S_ID;
                    end
                end
                S_PROG: begin
                    start     = 1'b1;
                    req.kind  = OP_PROG;
                    req.addr  = addr[ARR_W-1:0];
                    req.data  = wdata;
                    nxt       = S_READ;
                end
                S_ER1: nxt = (addr == UNLOCK_A0 && cmd == 8'hAA) ? S_ER2 : S_READ;
                S_ER2: nxt = (addr == UNLOCK_A1 && cmd == 8'h55) ? S_ER3 : S_READ;
                S_ER3: begin
                    nxt      = S_READ;
                    req.addr = addr[ARR_W-1:0];
                    req.data = '1;
                    if (cmd == 8'h30) begin
                        start    = 1'b1;
                        req.kind = OP_ERS_SECT;
                    end else if (addr == UNLOCK_A0 && cmd == 8'h10) begin
                        start    = 1'b1;
                        req.kind = OP_ERS_CHIP;
                    end
                end
                S_BUFC: begin
                    if (wdata > DATA_W'(BUF_WORDS - 1)) begin
                        err_set = 1'b1;
                        nxt     = S_READ;
                    end else begin
                        left_n = wdata[PAGE_AW:0] + 1'b1;
                        cnt_n  = wdata[PAGE_AW:0] + 1'b1;
                        nxt    = S_BUFD;
                    end
                end
                S_BUFD: begin
                    if (!page_hit) begin
                        err_set = 1'b1;
                        nxt     = S_READ;
                    end else begin
                        buf_we = 1'b1;
                        tgt_n  = wdata;
                        left_n = left_q - 1'b1;
                        if (left_q == 1) nxt = S_BUFK;
                    end
                end
                S_BUFK: begin
                    nxt = S_READ;
                    if (cmd == 8'h29 && page_hit) begin
                        start    = 1'b1;
                        req.kind = OP_BUF;
                        req.addr = {page_q, {PAGE_AW{1'b0}}};
                        req.data = tgt_q;
                        req.cnt  = cnt_q;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                S_ID: begin
                    if (cmd == 8'hF0) begin
                        nxt     = S_READ;
                        err_clr = 1'b1;
                    end else if (addr == QRY_ADDR && cmd == 8'h98) nxt = S_QRY;
                end
                S_QRY: begin
                    if (cmd == 8'hF0) begin
                        nxt     = S_READ;
                        err_clr = 1'b1;
                    end
                end
                default: nxt = S_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_READ;
            page_q <= '0;
            left_q <= '0;
            cnt_q  <= '0;
            tgt_q  <= '0;
            err    <= 1'b0;
        end else begin
            state  <= nxt;
            page_q <= page_n;
            left_q <= left_n;
            cnt_q  <= cnt_n;
            tgt_q  <= tgt_n;
            if (err_set) err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    always_comb begin
        case (state)
            S_ID:    mode = MODE_ID;
            S_QRY:   mode = MODE_QRY;
            default: mode = MODE_ARRAY;
        endcase
    end

    AST_BIG_COUNT_ERR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && state == S_BUFC && wdata > DATA_W'(BUF_WORDS - 1)) |=> err); // R11
    AST_QRY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && state == S_READ && addr == QRY_ADDR && cmd == 8'h98) |=> mode == MODE_QRY); // R8
    AST_UNLOCK_BREAK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && state == S_U1 && !(addr == UNLOCK_A1 && cmd == 8'h55)) |=> state == S_READ); // R7
    AST_BUSY_HOLDS_DECODER: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(state)); // R6
endmodule

// File: rtl/nfl_wbuf.sv
module nfl_wbuf
    import nfl_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 clr,
    input  logic                                 we,
    input  logic [PAGE_AW-1:0]                   idx,
    input  logic [DATA_W-1:0]                    din,
    output logic [BUF_WORDS-1:0]                 valid,
    output logic [BUF_WORDS-1:0][DATA_W-1:0]     words
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            words <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (we) begin
            valid[idx] <= 1'b1;
            words[idx] <= din;
        end
    end
endmodule

// File: rtl/nfl_array.sv
module nfl_array
    import nfl_pkg::*;
#(
    parameter int PROG_CYC       = 4,
    parameter int ERASE_PER_WORD = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  op_req_t                           req,
    input  logic [BUF_WORDS-1:0]              buf_valid,
    input  logic [BUF_WORDS-1:0][DATA_W-1:0]  buf_words,
    input  logic [ARR_W-1:0]                  raddr,
    output logic [DATA_W-1:0]                 rword,
    output logic [DATA_W-1:0]                 status,
    output logic                              busy
);
    localparam int CNT_W = $clog2(ARR_WORDS * ERASE_PER_WORD) + 1;
    localparam int PG_W  = ARR_W - PAGE_AW;

    logic [DATA_W-1:0] mem [ARR_WORDS];
    logic [CNT_W-1:0]  cnt_q;
    op_req_t           op_q;
    logic [CNT_W-1:0]  cyc;

    always_comb begin
        case (req.kind)
            OP_PROG:     cyc = CNT_W'(PROG_CYC);
            OP_ERS_SECT: cyc = CNT_W'(SECT_WORDS * ERASE_PER_WORD);
            OP_ERS_CHIP: cyc = CNT_W'(ARR_WORDS * ERASE_PER_WORD);
            default:     cyc = CNT_W'(PROG_CYC) + CNT_W'(req.cnt);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            op_q  <= '0;
            for (int i = 0; i < ARR_WORDS; i++) mem[i] <= '1;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                op_q  <= req;
                cnt_q <= cyc - 1'b1;
            end
        end else if (cnt_q != 0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            busy <= 1'b0;
            case (op_q.kind)
                OP_PROG: mem[op_q.addr] <= mem[op_q.addr] & op_q.data;
                OP_ERS_SECT: begin
                    for (int i = 0; i < ARR_WORDS; i++)
                        if ((ARR_W'(i) >> SECT_AW) == (op_q.addr >> SECT_AW)) mem[i] <= '1;
                end
                OP_ERS_CHIP: begin
                    for (int i = 0; i < ARR_WORDS; i++) mem[i] <= '1;
                end
                default: begin
                    for (int j = 0; j < BUF_WORDS; j++)
                        if (buf_valid[j])
                            mem[{op_q.addr[ARR_W-1:PAGE_AW], PAGE_AW'(j)}] <=
                                mem[{op_q.addr[ARR_W-1:PAGE_AW], PAGE_AW'(j)}] & buf_words[j];
                end
            endcase
        end
    end

    assign rword  = mem[raddr];
    assign status = {{(DATA_W-8){1'b0}}, ~op_q.data[7], 7'b0};

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy) && op_q.kind == OP_PROG) |->
        ((mem[op_q.addr] & ~$past(mem[op_q.addr])) == '0)); // R2
    AST_SECTOR_ERASED: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy) && op_q.kind == OP_ERS_SECT) |->
        (mem[{op_q.addr[ARR_W-1:SECT_AW], {SECT_AW{1'b0}}}] == '1)); // R3
    AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(op_q)); // R6
    AST_BUF_PAGE_BASE: assert property (@(posedge clk) disable iff (rst)
        (busy && op_q.kind == OP_BUF) |-> (op_q.addr[PAGE_AW-1:0] == '0 && op_q.cnt != 0)); // R10
    if (PG_W < 1) begin : g_bad_cfg
        initial $display("page field empty");
    end
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nfl_pkg::*;
#(
    parameter int PROG_CYC       = 4,
    parameter int ERASE_PER_WORD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [11:0]       addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              busy,
    output logic              err
);
    op_req_t                            req;
    logic                               start, buf_clr, buf_we;
    mode_e                              mode;
    logic [BUF_WORDS-1:0]               buf_valid;
    logic [BUF_WORDS-1:0][DATA_W-1:0]   buf_words;
    logic [DATA_W-1:0]                  arr_word, status;

    nfl_cmd_decode u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .start(start), .req(req), .buf_clr(buf_clr),
        .buf_we(buf_we), .mode(mode), .err(err)
    );

    nfl_wbuf u_buf (
        .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we),
        .idx(addr[PAGE_AW-1:0]), .din(wdata),
        .valid(buf_valid), .words(buf_words)
    );

    nfl_array #(.PROG_CYC(PROG_CYC), .ERASE_PER_WORD(ERASE_PER_WORD)) u_arr (
        .clk(clk), .rst(rst), .start(start), .req(req),
        .buf_valid(buf_valid), .buf_words(buf_words),
        .raddr(addr[ARR_W-1:0]), .rword(arr_word), .status(status), .busy(busy)
    );

    always_comb begin
        if (busy)                 rdata = status;
        else if (mode == MODE_ID)  rdata = id_word(addr[0]);
        else if (mode == MODE_QRY) rdata = query_word(addr[7:0]);
        else                      rdata = arr_word;
    end

    AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rdata[6:0] == '0 && rdata[15:8] == '0)); // R5
endmodule

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy, err;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    nor_cmd_engine u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .err(err)
    );

    // {is_write, requirement number, address, data or expected read}
    localparam int NV = 35;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 4'd1, 12'h000, 16'hFFFF},                                   // R1
        {1'b1, 4'd2, 12'h555, 16'h00AA}, {1'b1, 4'd2, 12'h2AA, 16'h0055},
        {1'b1, 4'd2, 12'h555, 16'h00A0}, {1'b1, 4'd2, 12'h010, 16'h1234},
        {1'b0, 4'd2, 12'h010, 16'h1234},                                   // R2
        {1'b1, 4'd2, 12'h555, 16'h00AA}, {1'b1, 4'd2, 12'h2AA, 16'h0055},
        {1'b1, 4'd2, 12'h555, 16'h00A0}, {1'b1, 4'd2, 12'h010, 16'h0F0F},
        {1'b0, 4'd2, 12'h010, 16'h0204},                                   // R2 AND
        {1'b1, 4'd7, 12'h555, 16'h00AA}, {1'b1, 4'd7, 12'h2AA, 16'h0011},
        {1'b1, 4'd7, 12'h555, 16'h00A0}, {1'b1, 4'd7, 12'h011, 16'h0000},
        {1'b0, 4'd7, 12'h011, 16'hFFFF},                                   // R7
        {1'b1, 4'd7, 12'h012, 16'h0000}, {1'b0, 4'd7, 12'h012, 16'hFFFF},  // R7
        {1'b1, 4'd9, 12'h555, 16'h00AA}, {1'b1, 4'd9, 12'h2AA, 16'h0055},
        {1'b1, 4'd9, 12'h555, 16'h0090},
        {1'b0, 4'd9, 12'h000, 16'h00C3}, {1'b0, 4'd9, 12'h001, 16'h2A7E},  // R9
        {1'b1, 4'd8, 12'h055, 16'h0098},
        {1'b0, 4'd8, 12'h010, 16'h0051}, {1'b0, 4'd8, 12'h011, 16'h0052},
        {1'b0, 4'd8, 12'h012, 16'h0059},                                   // R8
        {1'b1, 4'd9, 12'h123, 16'h00F0}, {1'b0, 4'd9, 12'h010, 16'h0204},  // R9
        {1'b1, 4'd8, 12'h056, 16'h0098}, {1'b0, 4'd8, 12'h011, 16'hFFFF},  // R8
        {1'b1, 4'd8, 12'h055, 16'h0098}, {1'b0, 4'd8, 12'h011, 16'h0052},
        {1'b1, 4'd8, 12'h000, 16'h00F0}, {1'b0, 4'd8, 12'h011, 16'hFFFF}
    };

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    endtask

    task automatic chk(input logic [11:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h rdata=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_val(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
    endtask

    task automatic erase_pre();
        unlock(); wr(12'h555, 16'h0080); unlock();
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_val(busy, 0, "R1 busy after reset");
        chk_val(err, 0, "R1 err after reset");

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][32]) begin
                wr(VEC[v][27:16], VEC[v][15:0]);
                wait_idle();
            end else begin
                addr = VEC[v][27:16];
                #1;
                checks++;
                if (rdata !== VEC[v][15:0]) begin
                    errors++;
                    $display("FAIL R%0d vector %0d rdata=%h expected=%h",
                             VEC[v][31:28], v, rdata, VEC[v][15:0]);
                end
                @(negedge clk);
            end
        end

        // R5: program busy length and status word
        unlock(); wr(12'h555, 16'h00A0); wr(12'h020, 16'h1234);
        chk(12'h020, 16'h0080, "R5 status during program");
        busy_len(n);
        chk_val(n, 4, "R5 program busy cycles");
        chk(12'h020, 16'h1234, "R5 programmed word");

        // R3: sector erase of sector 0
        unlock(); wr(12'h555, 16'h00A0); wr(12'h003, 16'h0000); wait_idle();
        erase_pre(); wr(12'h007, 16'h0030);
        chk(12'h003, 16'h0000, "R5 status during erase");
        busy_len(n);
        chk_val(n, 32, "R3 sector erase busy cycles");
        chk(12'h003, 16'hFFFF, "R3 erased word");
        chk(12'h010, 16'h0204, "R3 neighbour sector kept");
        chk(12'h020, 16'h1234, "R3 far sector kept");

        // R6: writes during busy are dropped
        erase_pre(); wr(12'h020, 16'h0030);
        unlock(); wr(12'h555, 16'h00A0);
        wait_idle();
        wr(12'h024, 16'h0000);
        chk(12'h024, 16'hFFFF, "R6 decoder not advanced while busy");
        chk(12'h020, 16'hFFFF, "R3 sector 2 erased");

        // R10: buffered program of three words
        unlock(); wr(12'h040, 16'h0025); wr(12'h040, 16'h0002);
        wr(12'h041, 16'h1111); wr(12'h042, 16'h2222); wr(12'h05F, 16'h4444);
        chk(12'h041, 16'hFFFF, "R10 no change before confirm");
        wr(12'h040, 16'h0029);
        busy_len(n);
        chk_val(n, 7, "R10 buffer busy cycles");
        chk(12'h041, 16'h1111, "R10 word 1");
        chk(12'h042, 16'h2222, "R10 word 2");
        chk(12'h05F, 16'h4444, "R10 word 3");
        unlock(); wr(12'h041, 16'h0025); wr(12'h041, 16'h0000);
        wr(12'h041, 16'h0F0F); wr(12'h041, 16'h0029); wait_idle();
        chk(12'h041, 16'h0101, "R10 buffered AND");

        // R11: aborts
        unlock(); wr(12'h040, 16'h0025); wr(12'h040, 16'h0020);
        chk_val(err, 1, "R11 oversize count sets err");
        wr(12'h050, 16'h0000);
        chk(12'h050, 16'hFFFF, "R11 no write after oversize abort");
        wr(12'h000, 16'h00F0);
        chk_val(err, 0, "R11 reset command clears err");
        unlock(); wr(12'h040, 16'h0025); wr(12'h040, 16'h0001);
        wr(12'h041, 16'h0000); wr(12'h060, 16'h0000);
        chk_val(err, 1, "R11 out-of-page sets err");
        wr(12'h040, 16'h0029);
        chk_val(busy, 0, "R11 no operation after abort");
        chk(12'h041, 16'h0101, "R11 array unchanged");
        wr(12'h000, 16'h00F0);

        // R4: whole-array erase
        erase_pre(); wr(12'h555, 16'h0010);
        busy_len(n);
        chk_val(n, 512, "R4 chip erase busy cycles");
        chk(12'h041, 16'hFFFF, "R4 word erased");
        chk(12'h0FF, 16'hFFFF, "R4 top word erased");

        // R1: reset during an operation
        unlock(); wr(12'h555, 16'h00A0); wr(12'h005, 16'h0000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_val(busy, 0, "R1 busy cleared by reset");
        chk(12'h005, 16'hFFFF, "R1 array after reset");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule